// File: doc/BRIEF.md
# UART Transmitter with Programmable Inter-Frame Gap

This block turns bytes into asynchronous serial frames on a single output line. Bytes enter through a write port into a 16-entry buffer. Whenever the line is free and the buffer holds data, the transmitter takes the oldest byte and sends a frame. Each frame is a low start bit, then eight data bits with the least significant bit first, then an optional parity bit, then a high stop bit. An external baud tick sets the length of every bit slot: one slot lasts from one tick to the next.

A guard interval separates frames. Its length is an 8-bit count of bit times. The line is held high for that many extra bit times after a stop bit, and only when another byte is already waiting. With a count of zero, frames follow each other with no idle time. When the buffer is empty at the end of a stop bit, the transmitter goes idle at once. A byte written later starts on the next baud tick.

The buffer reports when it is full and when it is empty. A write to a full buffer is thrown away and sets a flag that stays set until reset.

Top module: `uart_tx_gap`

## Requirements
- R1: After reset, txOut is 1, fifoEmpty is 1, fifoFull is 0 and overflow is 0.
- R2: A frame begins with one bit time of txOut = 0. Eight data bits follow, bit 0 first, each lasting one bit time. One bit time is the interval between two bitTick pulses.
- R3: parityMode 2'b01 selects even parity and 2'b10 selects odd parity. The parity bit follows data bit 7. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number of ones.
- R4: parityMode 2'b00 and 2'b11 omit the parity slot. A frame is then 10 bit times long.
- R5: Every frame ends with one bit time of txOut = 1, the stop bit.
- R6: If a byte is waiting when a stop bit ends, txOut stays 1 for exactly gapBits bit times before the next start bit. Start bits are then (10 + parity + gapBits) bit times apart.
- R7: With gapBits = 0, a waiting byte's start bit follows the previous stop bit directly.
- R8: If the buffer is empty when a stop bit ends, the line goes idle (txOut = 1) with no gap. A byte written later starts within one bit time plus two clock cycles of the write.
- R9: The buffer holds 16 bytes and sends them in write order. fifoFull is 1 after 16 unsent writes. fifoFull and fifoEmpty are never 1 together.
- R10: A write while fifoFull is 1 is dropped: the byte is never sent. The write sets overflow, which then stays 1 until reset.
- R11: txOut changes only in the clock cycle right after a cycle in which bitTick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the transmit buffer |
| wrData | input | 8 | Byte to queue |
| fifoFull | output | 1 | Buffer holds 16 bytes |
| fifoEmpty | output | 1 | Buffer holds no byte |
| overflow | output | 1 | Sticky: a write was dropped while the buffer was full |
| bitTick | input | 1 | One-cycle pulse marking each bit-time boundary |
| parityMode | input | 2 | 00/11 none, 01 even, 10 odd |
| gapBits | input | 8 | Guard interval between frames, in bit times |
| txOut | output | 1 | Serial line, idle high |

## Verification
A corrupted control state shows on the line within one bit time. A miscounted data index moves or shifts the parity and stop slots, so the frame decoded at the mid-bit sample points has wrong bits. A wrong gap count moves the next falling edge by whole multiples of the bit time, so the spacing between start bits exposes it at the next frame. Buffer pointer errors appear as bytes out of order, repeated or missing, and as full and empty flags that disagree with the number of bytes written minus the number of frames seen.

// File: rtl/uart_tx_gap_pkg.sv
package uart_tx_gap_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } parity_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PARITY,
    S_STOP,
    S_GAP
  } tx_state_e;

  // strobes from control to datapath, all acting on a bit-time boundary
  typedef struct packed {
    logic load;        // pop the FIFO, capture byte, drive start bit
    logic emitData;    // drive next data bit and shift
    logic emitParity;  // drive parity bit
    logic emitHigh;    // drive stop / idle level
  } tx_strobe_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty,
  output logic             overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wrPtr, rdPtr;

  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign rdData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wrEn && !full) mem[wrPtr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wrEn && !full)  wrPtr <= wrPtr + 1'b1;
      if (wrEn && full)   overflow <= 1'b1;
      if (rdEn && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_gap_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int GAP_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             fifoEmpty,
  input  logic             parityOn,
  input  logic [GAP_W-1:0] gapBits,
  output tx_strobe_t       strobe
);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  tx_state_e        state, nextState;
  logic [IDX_W-1:0] bitIdx, nextIdx;
  logic [GAP_W-1:0] gapCnt, nextGap;

  always_comb begin
    nextState = state;
    nextIdx   = bitIdx;
    nextGap   = gapCnt;
    strobe    = '0;
    if (bitTick) begin
      unique case (state)
        S_IDLE: begin
          if (!fifoEmpty) begin
            strobe.load = 1'b1;
            nextState   = S_START;
          end
        end
        S_START: begin
          strobe.emitData = 1'b1;
          nextIdx         = '0;
          nextState       = S_DATA;
        end
        S_DATA: begin
          if (bitIdx == LAST_IDX) begin
            if (parityOn) begin
              strobe.emitParity = 1'b1;
              nextState         = S_PARITY;
            end else begin
              strobe.emitHigh = 1'b1;
              nextState       = S_STOP;
            end
          end else begin
            strobe.emitData = 1'b1;
            nextIdx         = bitIdx + 1'b1;
          end
        end
        S_PARITY: begin
          strobe.emitHigh = 1'b1;
          nextState       = S_STOP;
        end
        S_STOP: begin
          if (fifoEmpty) begin
            nextState = S_IDLE;
          end else if (gapBits == '0) begin
            strobe.load = 1'b1;
            nextState   = S_START;
          end else begin
            nextGap   = gapBits;
            nextState = S_GAP;
          end
        end
        S_GAP: begin
          if (gapCnt == GAP_W'(1)) begin
            if (fifoEmpty) begin
              nextState = S_IDLE;
            end else begin
              strobe.load = 1'b1;
              nextState   = S_START;
            end
          end else begin
            nextGap = gapCnt - 1'b1;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitIdx <= '0;
      gapCnt <= '0;
    end else begin
      state  <= nextState;
      bitIdx <= nextIdx;
      gapCnt <= nextGap;
    end
  end
endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_gap_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tx_strobe_t           strobe,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic [1:0]           parityMode,
  output logic                 txOut
);
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parityBit;
  logic                 oddSel;

  assign oddSel = (parityMode == PAR_ODD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      txOut     <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftReg  <= txByte;
        parityBit <= (^txByte) ^ oddSel;
        txOut     <= 1'b0;
      end else if (strobe.emitData) begin
        txOut    <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strobe.emitParity) begin
        txOut <= parityBit;
      end else if (strobe.emitHigh) begin
        txOut <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_gap.sv
module uart_tx_gap
  import uart_tx_gap_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int GAP_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [DATA_BITS-1:0] wrData,
  output logic                 fifoFull,
  output logic                 fifoEmpty,
  output logic                 overflow,
  input  logic                 bitTick,
  input  logic [1:0]           parityMode,
  input  logic [GAP_W-1:0]     gapBits,
  output logic                 txOut
);
  tx_strobe_t           strobe;
  logic [DATA_BITS-1:0] headByte;
  logic                 parityOn;

  assign parityOn = (parityMode == PAR_EVEN) || (parityMode == PAR_ODD);

  uart_tx_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(strobe.load), .rdData(headByte),
    .full(fifoFull), .empty(fifoEmpty), .overflow(overflow)
  );

  uart_tx_ctrl #(.DATA_BITS(DATA_BITS), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .fifoEmpty(fifoEmpty),
    .parityOn(parityOn), .gapBits(gapBits), .strobe(strobe)
  );

  uart_tx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(headByte),
    .parityMode(parityMode), .txOut(txOut)
  );
endmodule

// File: rtl/uart_tx_gap_chk.sv
module uart_tx_gap_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic fifoFull,
  input logic fifoEmpty,
  input logic overflow,
  input logic bitTick,
  input logic txOut
);
  // R11
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitTick) |-> $stable(txOut));

  // R10
  no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R10
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fifoFull) |=> overflow);

  // R9
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));
endmodule

bind uart_tx_gap uart_tx_gap_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty), .overflow(overflow), .bitTick(bitTick), .txOut(txOut)
);

// File: tb/sim_uart_tx_gap.sv
module sim_uart_tx_gap;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       fifoFull, fifoEmpty, overflow, txOut;
  logic       bitTick = 1'b0;
  logic [1:0] parityMode = 2'b00;
  logic [7:0] gapBits = '0;

  typedef struct {
    logic [7:0] data;
    logic [1:0] mode;
  } item_t;

  item_t  sbQ[$];
  longint startQ[$];
  longint cyc = 0;
  int     nRun = 0;
  int     nFail = 0;
  bit     tickEn = 1'b1;
  bit     inFrame = 1'b0;

  uart_tx_gap u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .overflow(overflow),
    .bitTick(bitTick), .parityMode(parityMode), .gapBits(gapBits), .txOut(txOut)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // baud tick generator
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (tickEn) begin
        cnt     = (cnt == DIV - 1) ? 0 : cnt + 1;
        bitTick = (cnt == 0);
      end else begin
        bitTick = 1'b0;
      end
    end
  end

  // monitor: decode frames at mid-bit and compare against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txOut === 1'b0) begin
        item_t      exp;
        logic [7:0] got;
        logic       expPar;
        inFrame = 1'b1;
        startQ.push_back(cyc);
        repeat (DIV / 2) @(negedge clk);
        check(txOut === 1'b0, "R2", "start bit level", txOut, 0);
        if (sbQ.size() == 0) begin
          check(1'b0, "R10", "unexpected frame", 1, 0);
          exp = '{8'h00, 2'b00};
        end else begin
          exp = sbQ.pop_front();
        end
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          got[i] = txOut;
        end
        check(got === exp.data, "R2 R9", "data byte LSB first", got, exp.data);
        if (exp.mode == 2'b01 || exp.mode == 2'b10) begin
          repeat (DIV) @(negedge clk);
          expPar = (^exp.data) ^ (exp.mode == 2'b10);
          check(txOut === expPar, "R3", "parity bit", txOut, expPar);
        end
        repeat (DIV) @(negedge clk);
        check(txOut === 1'b1, "R5", "stop bit level", txOut, 1);
        inFrame = 1'b0;
      end
    end
  end

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wrEn   = 1'b1;
    wrData = d;
    sbQ.push_back('{d, parityMode});
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (sbQ.size() != 0 || inFrame || !fifoEmpty);
    repeat (2 * DIV) @(negedge clk);
  endtask

  initial begin
    repeat (5000 * 30) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    longint wAt;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(txOut === 1'b1, "R1", "txOut after reset", txOut, 1);
    check(fifoEmpty === 1'b1, "R1", "fifoEmpty after reset", fifoEmpty, 1);
    check(fifoFull === 1'b0, "R1", "fifoFull after reset", fifoFull, 0);
    check(overflow === 1'b0, "R1", "overflow after reset", overflow, 0);

    // R2 R5 R8: single byte, no parity, then idle
    parityMode = 2'b00; gapBits = 8'd0;
    push(8'hA5);
    drain();
    check(txOut === 1'b1 && fifoEmpty === 1'b1, "R8", "idle high after last frame", txOut, 1);

    // R3: even and odd parity
    parityMode = 2'b01;
    push(8'h3C); push(8'h01);
    drain();
    parityMode = 2'b10;
    push(8'h7F); push(8'h00);
    drain();

    // R4: mode 11 omits parity slot
    parityMode = 2'b11; gapBits = 8'd0;
    startQ.delete();
    push(8'h96); push(8'h5A);
    drain();
    check(startQ.size() == 2 && startQ[1] - startQ[0] == 10 * DIV, "R4",
          "frame spacing, parity off", startQ[1] - startQ[0], 10 * DIV);

    // R7: gap zero, back-to-back
    parityMode = 2'b00;
    startQ.delete();
    push(8'h11); push(8'h22); push(8'h33);
    drain();
    check(startQ[1] - startQ[0] == 10 * DIV, "R7", "back-to-back 1", startQ[1] - startQ[0], 10 * DIV);
    check(startQ[2] - startQ[1] == 10 * DIV, "R7", "back-to-back 2", startQ[2] - startQ[1], 10 * DIV);

    // R6: gap of 3 bit times with even parity
    parityMode = 2'b01; gapBits = 8'd3;
    startQ.delete();
    push(8'h44); push(8'h55);
    drain();
    check(startQ[1] - startQ[0] == 14 * DIV, "R6", "gap spacing", startQ[1] - startQ[0], 14 * DIV);

    // R8: empty at stop end -> no gap; a later byte starts promptly
    parityMode = 2'b00; gapBits = 8'd200;
    push(8'h66);
    drain();
    repeat (3 * DIV) @(negedge clk);
    startQ.delete();
    wAt = cyc;
    push(8'h77);
    drain();
    check(startQ.size() == 1, "R8", "frames after late write", startQ.size(), 1);
    check(startQ[0] - wAt >= 1 && startQ[0] - wAt <= DIV + 3, "R8", "start latency",
          startQ[0] - wAt, DIV);

    // R9 R10 R11: fill with ticks stopped
    tickEn = 1'b0;
    parityMode = 2'b10; gapBits = 8'd1;
    repeat (2 * DIV) @(negedge clk);
    startQ.delete();
    for (int i = 0; i < 16; i++) push(8'(i * 13 + 5));
    @(negedge clk);
    check(fifoFull === 1'b1, "R9", "full after 16 writes", fifoFull, 1);
    check(overflow === 1'b0, "R10", "no overflow before drop", overflow, 0);
    check(txOut === 1'b1, "R11", "line still without ticks", txOut, 1);
    @(negedge clk); wrEn = 1'b1; wrData = 8'hEE;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    check(overflow === 1'b1, "R10", "overflow after drop", overflow, 1);
    check(fifoFull === 1'b1, "R10", "still full after drop", fifoFull, 1);
    tickEn = 1'b1;
    drain();
    check(startQ.size() == 16, "R10", "frames sent, dropped byte absent", startQ.size(), 16);
    check(startQ[1] - startQ[0] == 12 * DIV, "R6", "gap 1 odd parity spacing",
          startQ[1] - startQ[0], 12 * DIV);
    check(overflow === 1'b1, "R10", "overflow sticky", overflow, 1);
    check(fifoEmpty === 1'b1 && fifoFull === 1'b0, "R9", "empty after drain", fifoEmpty, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule